// File: doc/BRIEF.md
# System Clock Mode Sequencer

This block steers the system clock of a small processor among its operating modes. Software writes one configuration word at a time. The word carries a PLL enable, a CPU clock source select, a three-bit gear code, a PLL multiplier choice and a standby selection. A halt strobe moves the block from a run mode into the standby level that software chose. An interrupt wake input brings it back.

The block does not generate clocks. It reports the current mode, the divide ratio and multiply factor to apply, and enable levels for the CPU clock, the peripheral clock, the oscillator and the PLL. The PLL settling time is modelled by a lock counter. The oscillator restart after a stop is modelled by a warm-up counter. Unsafe sequences are refused in hardware and recorded in a sticky error flag:
- disabling a PLL that still drives the CPU;
- stopping while the PLL is enabled.

Top module: `clkmode_ctrl`

## Requirements
- R1: After a synchronous reset the block is in mode 0 (oscillator run). The outputs are gear_div 16, mul_factor 1, cpu_clk_en, per_clk_en and osc_en high, and pll_en, pll_locked and err_flag low.
- R2: The gear codes 0, 1, 2, 3 and 4 give gear_div values 1, 2, 4, 8 and 16. Codes 5, 6 and 7 give 16.
- R3: pll_locked rises LOCK_CYC cycles after pll_en rises. It falls on the cycle after pll_en falls.
- R4: A write requesting the PLL as CPU source takes effect only if pll_locked is high and the same write keeps the PLL enabled. Otherwise the source stays on the oscillator. While the PLL drives the CPU, the mode is 1 and mul_factor is 12 (multiplier bit 0) or 16 (multiplier bit 1). In oscillator run, mul_factor is 1.
- R5: A write that clears the PLL enable while the PLL is the CPU source leaves the PLL enabled and sets err_flag. The same write may still move the source back to the oscillator.
- R6: A halt in a run mode with standby code 0 enters mode 2: CPU clock off, peripheral clock and oscillator on. Standby code 1 enters mode 3: only the oscillator on.
- R7: A halt in a run mode with standby code 2 or 3, while the PLL is disabled, enters mode 4. In mode 4 the CPU clock, peripheral clock, oscillator and PLL enables are all low.
- R8: A halt asking for stop while the PLL is enabled is refused. The mode is unchanged and err_flag is set.
- R9: A wake in mode 2 or 3 returns to the run mode that was left: mode 1 if the PLL is the source, otherwise mode 0.
- R10: A wake in mode 4 enters mode 5 (warm-up). Mode 5 lasts WARM_CYC cycles with only the oscillator enabled, then the block goes to mode 0.
- R11: Configuration writes outside modes 0 and 1 are ignored.
- R12: err_flag, once set, stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pll_on | input | 1 | Requested PLL enable |
| cfg_sel_pll | input | 1 | Requested CPU source: 1 = PLL |
| cfg_gear | input | GEAR_W | Gear code |
| cfg_mul16 | input | 1 | PLL multiplier: 0 = 12, 1 = 16 |
| cfg_stby | input | 2 | Standby level for the next halt |
| halt | input | 1 | Halt instruction strobe |
| wake_irq | input | 1 | Interrupt wake request |
| mode | output | 3 | Mode code 0..5 |
| gear_div | output | DIV_MAX_LOG+1 | System clock divide ratio |
| mul_factor | output | MUL_W | PLL multiply factor, 1 when not on the PLL |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| pll_locked | output | 1 | PLL lock counter expired |
| err_flag | output | 1 | Sticky illegal-sequence flag |

## Verification
The bench builds the block with LOCK_CYC set to 5 and WARM_CYC set to 4, in place of the long default settling times. With these values the bench can observe several things exactly:
- a select request that arrives before lock and is rejected;
- the precise cycle on which lock is reached;
- every cycle of the warm-up window.

Within those windows the bench can also try writes during standby and PLL clears. The default gear width and multiplier values are kept, so all eight gear codes are swept, including the three codes that clamp to the largest divide ratio.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [2:0] {
    PH_RUN      = 3'd0,
    PH_IDLE_IO  = 3'd1,
    PH_IDLE_OSC = 3'd2,
    PH_STOP     = 3'd3,
    PH_WARM     = 3'd4
  } phase_e;

  localparam logic [2:0] MD_OSC      = 3'd0;
  localparam logic [2:0] MD_PLL      = 3'd1;
  localparam logic [2:0] MD_IDLE_IO  = 3'd2;
  localparam logic [2:0] MD_IDLE_OSC = 3'd3;
  localparam logic [2:0] MD_STOP     = 3'd4;
  localparam logic [2:0] MD_WARM     = 3'd5;

  localparam logic [1:0] SB_IDLE_IO  = 2'd0;
  localparam logic [1:0] SB_IDLE_OSC = 2'd1;
endpackage

// File: rtl/clkmode_lock.sv
module clkmode_lock #(
  parameter int LOCK_CYC = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_on,
  output logic locked
);
  localparam int LCW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
  localparam logic [LCW-1:0] LAST = LCW'(LOCK_CYC - 1);

  logic [LCW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pll_on) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (!locked) begin
      if (cnt == LAST) locked <= 1'b1;
      else             cnt    <= cnt + 1'b1;
    end
  end

  p_lock_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(pll_on));
  p_lock_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> !$past(pll_on));
endmodule

// File: rtl/clkmode_cfg.sv
module clkmode_cfg #(
  parameter int GEAR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic              cfg_wr,
  input  logic              cfg_pll_on,
  input  logic              cfg_sel_pll,
  input  logic [GEAR_W-1:0] cfg_gear,
  input  logic              cfg_mul16,
  input  logic [1:0]        cfg_stby,
  input  logic              locked,
  output logic              pll_on,
  output logic              sel_pll,
  output logic [GEAR_W-1:0] gear,
  output logic              mul16,
  output logic [1:0]        stby,
  output logic              bad_clear
);
  localparam logic [GEAR_W-1:0] GEAR_RST = GEAR_W'(4);

  logic take;
  logic pll_next;

  assign take      = wr_ok && cfg_wr;
  assign bad_clear = take && pll_on && sel_pll && !cfg_pll_on;
  assign pll_next  = bad_clear ? 1'b1 : cfg_pll_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_on  <= 1'b0;
      sel_pll <= 1'b0;
      gear    <= GEAR_RST;
      mul16   <= 1'b0;
      stby    <= '0;
    end else if (take) begin
      pll_on  <= pll_next;
      sel_pll <= cfg_sel_pll && locked && pll_next;
      gear    <= cfg_gear;
      mul16   <= cfg_mul16;
      stby    <= cfg_stby;
    end
  end

  p_sel_needs_pll_r4: assert property (@(posedge clk) disable iff (rst)
    sel_pll |-> pll_on);
  p_sel_rise_locked_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_pll) |-> $past(locked));
  p_pll_kept_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_pll) && $past(pll_on)) |-> pll_on);
  p_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!wr_ok) |-> ($stable(gear) && $stable(pll_on) && $stable(stby)));
endmodule

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
  import clkmode_pkg::*;
#(
  parameter int WARM_CYC = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pll_on,
  input  logic [1:0] stby,
  input  logic       halt,
  input  logic       wake_irq,
  output phase_e     phase,
  output logic       stop_refused
);
  localparam int WCW = (WARM_CYC > 1) ? $clog2(WARM_CYC) : 1;
  localparam logic [WCW-1:0] WLAST = WCW'(WARM_CYC - 1);

  logic [WCW-1:0] wcnt;
  logic           want_stop;

  assign want_stop    = (phase == PH_RUN) && halt &&
                        (stby != SB_IDLE_IO) && (stby != SB_IDLE_OSC);
  assign stop_refused = want_stop && pll_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_RUN;
      wcnt  <= '0;
    end else begin
      unique case (phase)
        PH_RUN: begin
          if (halt) begin
            if (stby == SB_IDLE_IO)       phase <= PH_IDLE_IO;
            else if (stby == SB_IDLE_OSC) phase <= PH_IDLE_OSC;
            else if (!pll_on)             phase <= PH_STOP;
          end
        end
        PH_IDLE_IO, PH_IDLE_OSC: begin
          if (wake_irq) phase <= PH_RUN;
        end
        PH_STOP: begin
          wcnt <= '0;
          if (wake_irq) phase <= PH_WARM;
        end
        PH_WARM: begin
          if (wcnt == WLAST) phase <= PH_RUN;
          else               wcnt  <= wcnt + 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  p_idle_by_halt_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(phase == PH_RUN) && phase != PH_RUN) |-> $past(halt));
  p_stop_no_pll_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STOP) |-> !pll_on);
  p_no_skip_warm_r10: assert property (@(posedge clk) disable iff (rst)
    $past(phase == PH_STOP) |-> (phase != PH_RUN));
  p_warm_from_stop_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(phase == PH_WARM) |-> $past(phase == PH_STOP));
endmodule

// File: rtl/clkmode_decode.sv
module clkmode_decode
  import clkmode_pkg::*;
#(
  parameter int GEAR_W      = 3,
  parameter int DIV_MAX_LOG = 4,
  parameter int MUL_LO      = 12,
  parameter int MUL_HI      = 16,
  parameter int MUL_W       = 5
) (
  input  phase_e                 phase,
  input  logic                   sel_pll,
  input  logic [GEAR_W-1:0]      gear,
  input  logic                   mul16,
  output logic [2:0]             mode,
  output logic [DIV_MAX_LOG:0]   gear_div,
  output logic [MUL_W-1:0]       mul_factor,
  output logic                   cpu_clk_en,
  output logic                   per_clk_en,
  output logic                   osc_en
);
  localparam logic [GEAR_W-1:0] GMAX = GEAR_W'(DIV_MAX_LOG);

  logic [GEAR_W-1:0] gsel;
  assign gsel = (gear > GMAX) ? GMAX : gear;

  for (genvar i = 0; i <= DIV_MAX_LOG; i++) begin : g_div
    assign gear_div[i] = (gsel == GEAR_W'(i));
  end

  always_comb begin
    mode       = MD_OSC;
    cpu_clk_en = 1'b0;
    per_clk_en = 1'b0;
    osc_en     = 1'b1;
    unique case (phase)
      PH_RUN: begin
        mode       = sel_pll ? MD_PLL : MD_OSC;
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
      end
      PH_IDLE_IO: begin
        mode       = MD_IDLE_IO;
        per_clk_en = 1'b1;
      end
      PH_IDLE_OSC: mode = MD_IDLE_OSC;
      PH_STOP: begin
        mode   = MD_STOP;
        osc_en = 1'b0;
      end
      PH_WARM: mode = MD_WARM;
      default: mode = MD_OSC;
    endcase
  end

  assign mul_factor = !sel_pll ? MUL_W'(1) : (mul16 ? MUL_W'(MUL_HI) : MUL_W'(MUL_LO));
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int GEAR_W      = 3,
  parameter int DIV_MAX_LOG = 4,
  parameter int MUL_LO      = 12,
  parameter int MUL_HI      = 16,
  parameter int LOCK_CYC    = 2048,
  parameter int WARM_CYC    = 1024,
  localparam int MUL_W      = $clog2(MUL_HI + 1),
  localparam int DIV_W      = DIV_MAX_LOG + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_pll_on,
  input  logic              cfg_sel_pll,
  input  logic [GEAR_W-1:0] cfg_gear,
  input  logic              cfg_mul16,
  input  logic [1:0]        cfg_stby,
  input  logic              halt,
  input  logic              wake_irq,
  output logic [2:0]        mode,
  output logic [DIV_W-1:0]  gear_div,
  output logic [MUL_W-1:0]  mul_factor,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              pll_en,
  output logic              pll_locked,
  output logic              err_flag
);
  phase_e            phase;
  logic              pll_on, sel_pll, mul16, bad_clear, stop_refused;
  logic [GEAR_W-1:0] gear;
  logic [1:0]        stby;

  clkmode_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst(rst), .pll_on(pll_on), .locked(pll_locked)
  );

  clkmode_cfg #(.GEAR_W(GEAR_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_ok(phase == PH_RUN), .cfg_wr(cfg_wr),
    .cfg_pll_on(cfg_pll_on), .cfg_sel_pll(cfg_sel_pll), .cfg_gear(cfg_gear),
    .cfg_mul16(cfg_mul16), .cfg_stby(cfg_stby), .locked(pll_locked),
    .pll_on(pll_on), .sel_pll(sel_pll), .gear(gear), .mul16(mul16),
    .stby(stby), .bad_clear(bad_clear)
  );

  clkmode_fsm #(.WARM_CYC(WARM_CYC)) u_fsm (
    .clk(clk), .rst(rst), .pll_on(pll_on), .stby(stby), .halt(halt),
    .wake_irq(wake_irq), .phase(phase), .stop_refused(stop_refused)
  );

  clkmode_decode #(
    .GEAR_W(GEAR_W), .DIV_MAX_LOG(DIV_MAX_LOG), .MUL_LO(MUL_LO),
    .MUL_HI(MUL_HI), .MUL_W(MUL_W)
  ) u_dec (
    .phase(phase), .sel_pll(sel_pll), .gear(gear), .mul16(mul16),
    .mode(mode), .gear_div(gear_div), .mul_factor(mul_factor),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en)
  );

  assign pll_en = pll_on;

  always_ff @(posedge clk) begin
    if (rst)                            err_flag <= 1'b0;
    else if (bad_clear || stop_refused) err_flag <= 1'b1;
  end

  p_div_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(gear_div) == 1);
  p_stop_all_off_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_STOP) |-> !(cpu_clk_en || per_clk_en || osc_en || pll_en));
  p_refuse_sets_err_r8: assert property (@(posedge clk) disable iff (rst)
    stop_refused |=> (err_flag && mode != MD_STOP));
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    !$fell(err_flag));
endmodule

// File: tb/tb_clkmode_ctrl.sv
module tb_clkmode_ctrl;
  localparam int LOCK = 5;
  localparam int WARM = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 0, cfg_pll_on = 0, cfg_sel_pll = 0, cfg_mul16 = 0;
  logic [2:0] cfg_gear = 0;
  logic [1:0] cfg_stby = 0;
  logic       halt = 0, wake_irq = 0;
  logic [2:0] mode;
  logic [4:0] gear_div, mul_factor;
  logic       cpu_clk_en, per_clk_en, osc_en, pll_en, pll_locked, err_flag;

  clkmode_ctrl #(.LOCK_CYC(LOCK), .WARM_CYC(WARM)) dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_pll_on(cfg_pll_on),
    .cfg_sel_pll(cfg_sel_pll), .cfg_gear(cfg_gear), .cfg_mul16(cfg_mul16),
    .cfg_stby(cfg_stby), .halt(halt), .wake_irq(wake_irq), .mode(mode),
    .gear_div(gear_div), .mul_factor(mul_factor), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .pll_en(pll_en),
    .pll_locked(pll_locked), .err_flag(err_flag)
  );

  always #5 clk = ~clk;

  int    compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";

  // reference state: phase 0 run, 1 idle-io, 2 idle-osc, 3 stop, 4 warm
  int m_ph = 0, m_pll = 0, m_sel = 0, m_gear = 4, m_mul = 0, m_stby = 0;
  int m_err = 0, m_lock = 0, m_lcnt = 0, m_wcnt = 0;

  always @(posedge clk) begin
    int n_ph, n_pll, n_sel, n_gear, n_mul, n_stby, n_err, n_lock, n_lcnt, n_wcnt;
    cycles++;
    if (rst) begin
      n_ph = 0; n_pll = 0; n_sel = 0; n_gear = 4; n_mul = 0; n_stby = 0;
      n_err = 0; n_lock = 0; n_lcnt = 0; n_wcnt = 0;
    end else begin
      n_ph = m_ph; n_pll = m_pll; n_sel = m_sel; n_gear = m_gear; n_mul = m_mul;
      n_stby = m_stby; n_err = m_err; n_lock = m_lock; n_lcnt = m_lcnt; n_wcnt = m_wcnt;
      if (m_pll == 0) begin n_lock = 0; n_lcnt = 0; end
      else if (m_lock == 0) begin
        if (m_lcnt == LOCK - 1) n_lock = 1; else n_lcnt = m_lcnt + 1;
      end
      if (m_ph == 0 && cfg_wr) begin
        if (m_pll == 1 && m_sel == 1 && !cfg_pll_on) begin n_pll = 1; n_err = 1; end
        else n_pll = cfg_pll_on;
        n_sel = (cfg_sel_pll && m_lock == 1 && n_pll == 1) ? 1 : 0;
        n_gear = cfg_gear; n_mul = cfg_mul16; n_stby = cfg_stby;
      end
      case (m_ph)
        0: if (halt) begin
             if (m_stby == 0) n_ph = 1;
             else if (m_stby == 1) n_ph = 2;
             else if (m_pll == 0) n_ph = 3;
             else n_err = 1;
           end
        1, 2: if (wake_irq) n_ph = 0;
        3: begin n_wcnt = 0; if (wake_irq) n_ph = 4; end
        default: if (m_wcnt == WARM - 1) n_ph = 0; else n_wcnt = m_wcnt + 1;
      endcase
    end
    m_ph = n_ph; m_pll = n_pll; m_sel = n_sel; m_gear = n_gear; m_mul = n_mul;
    m_stby = n_stby; m_err = n_err; m_lock = n_lock; m_lcnt = n_lcnt; m_wcnt = n_wcnt;
  end

  task automatic chk(string nm, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int e_mode, e_div, e_mul;
      e_mode = (m_ph == 0) ? m_sel : m_ph + 1;
      e_div  = (m_gear > 4) ? 16 : (1 << m_gear);
      e_mul  = (m_sel == 0) ? 1 : (m_mul ? 16 : 12);
      chk("mode", mode, e_mode);
      chk("gear_div", gear_div, e_div);
      chk("mul_factor", mul_factor, e_mul);
      chk("cpu_clk_en", cpu_clk_en, m_ph == 0);
      chk("per_clk_en", per_clk_en, m_ph <= 1);
      chk("osc_en", osc_en, m_ph != 3);
      chk("pll_en", pll_en, m_pll);
      chk("pll_locked", pll_locked, m_lock);
      chk("err_flag", err_flag, m_err);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    cfg_wr = 0; halt = 0; wake_irq = 0;
  endtask

  task automatic wr(bit p, bit s, int g, bit m, int sb);
    cfg_wr = 1; cfg_pll_on = p; cfg_sel_pll = s; cfg_gear = 3'(g);
    cfg_mul16 = m; cfg_stby = 2'(sb);
    step(1);
  endtask

  task automatic do_halt(); halt = 1; step(1); endtask
  task automatic do_wake(); wake_irq = 1; step(1); endtask

  initial begin
    step(3); rst = 0;
    cur_req = "R1"; step(2);
    cur_req = "R2";
    for (int g = 0; g < 8; g++) begin wr(0, 0, g, 0, 0); step(1); end
    cur_req = "R4"; wr(1, 1, 2, 0, 0); step(1);        // early select rejected
    cur_req = "R3"; step(LOCK + 1);
    cur_req = "R4"; wr(1, 1, 2, 0, 0); step(2);
    wr(1, 1, 2, 1, 0); step(1);
    cur_req = "R6"; do_halt(); step(2);
    cur_req = "R11"; wr(0, 0, 0, 0, 2); step(2);
    cur_req = "R9"; do_wake(); step(2);
    cur_req = "R8"; wr(1, 1, 2, 1, 2); do_halt(); step(2);
    cur_req = "R5"; wr(0, 0, 1, 0, 1); step(2);
    cur_req = "R3"; wr(0, 0, 1, 0, 1); step(3);
    cur_req = "R6"; do_halt(); step(2);
    cur_req = "R9"; do_wake(); step(2);
    cur_req = "R7"; wr(0, 0, 3, 0, 3); do_halt(); step(3);
    cur_req = "R11"; wr(1, 0, 0, 0, 0); step(1);
    cur_req = "R10"; do_wake(); step(WARM + 2);
    cur_req = "R12"; step(3);
    cur_req = "R1"; rst = 1; step(2); rst = 0; step(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule